// File: doc/BRIEF.md
# Audio Packet Header Inserter

This block sits between the output of an audio encoder's byte FIFO and a transport multiplexer. It pops encoded audio bytes from a first-word-fall-through FIFO in bursts of one frame, which start whenever the FIFO signals half-full. It watches the popped bytes for the four-byte frame sync word and locks onto the frame grid. It then places a 14-byte packetized-elementary-stream header ahead of every following frame.

Once locked, a byte counter walks one frame length per frame. Its wrap marks the end of each frame and produces a one-cycle frame-sync pulse. That pulse is the moment the 33-bit timestamp is captured. While the header is being emitted, FIFO reads are held off, so every audio byte reaches the output in order and none is dropped. An empty FIFO simply pauses the byte stream and the frame count.

Top module: `aud_pes_inserter`

## Requirements
- R1: While rst_n is low, fifo_rd_en, out_valid, pkt_start and frame_sync are all 0.
- R2: No byte is popped until fifo_half has been sampled high while idle. fifo_rd_en can rise in the cycle after the clock edge that samples it.
- R3: A read burst ends after FRAME_LEN pops. Reading stays stopped until fifo_half is sampled high again.
- R4: Each popped byte (a cycle with fifo_rd_en high, which also needs fifo_empty low) is presented on out_data in the next cycle, with out_valid high and pkt_start low. The value and order are unchanged.
- R5: Four consecutive popped bytes FF, FD, C4, 00 lock the frame grid, and the FF byte is frame byte 0. frame_sync is high for exactly one cycle, in the cycle after the pop of frame byte FRAME_LEN-1. The same happens for every later frame of FRAME_LEN bytes. A sync word inside a frame after lock does not move the grid.
- R6: After each frame_sync, 14 header bytes follow on consecutive cycles starting one cycle after frame_sync, with pkt_start high only on the first. In order they are: 00, 00, 01, C0; the packet length (PKT_LEN) high byte, then low byte; 80, 80, 05. Then five timestamp bytes: {0010, ts[32:30], 1}, ts[29:22], {ts[21:15], 1}, ts[14:7], {ts[6:0], 1}.
- R7: The timestamp in a header is the value on pts in the cycle of the pop that ended the frame. Later changes of pts do not alter that header.
- R8: fifo_rd_en is low for the 14 cycles starting with the frame_sync cycle. Audio bytes resume right after the last header byte, with no byte lost.
- R9: When the FIFO goes empty, no pop occurs, out_valid drops and the frame count holds. The output stream is the same as with an uninterrupted FIFO.
- R10: Bytes popped before lock pass through unchanged, and no header is inserted for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_rdata | input | 8 | Head byte of the FIFO (valid while not empty) |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_half | input | 1 | FIFO is at least half full |
| fifo_rd_en | output | 1 | Pops the head byte on this clock edge |
| pts | input | 33 | Running presentation timestamp |
| out_data | output | 8 | Output byte to the multiplexer |
| out_valid | output | 1 | out_data carries a byte this cycle |
| pkt_start | output | 1 | First byte of a packet header |
| frame_sync | output | 1 | One-cycle pulse at each frame end; timestamp captured |

## Verification
The bench places a sync word inside a frame's payload. A design that re-aligned on it would insert the header mid-frame. FIFO underruns are forced in the middle of frames and inside header insertion. A counter that kept running without pops would misplace headers, and a read that ignored empty would duplicate bytes. The timestamp source is stepped right after each frame_sync, which catches a header that samples pts late instead of using the captured value. Half-full gating is exercised with the flag held low and then pulsed. This exposes a reader that starts without the flag or that fails to stop after one frame.

// File: rtl/aud_pes_pkg.sv
// Shared constants, types and the header byte table for the packet inserter.
package aud_pes_pkg;

    localparam int          HDR_LEN   = 14;
    localparam logic [31:0] SYNC_WORD = 32'hFFFD_C400;

    typedef enum logic {RD_IDLE, RD_BURST} rd_state_e;

    // Returns header byte number idx for a given packet length and timestamp.
    function automatic logic [7:0] pes_hdr_byte(input logic [3:0]  idx,
                                                input logic [15:0] plen,
                                                input logic [32:0] ts);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h00;
            4'd1:    b = 8'h00;
            4'd2:    b = 8'h01;
            4'd3:    b = 8'hC0;
            4'd4:    b = plen[15:8];
            4'd5:    b = plen[7:0];
            4'd6:    b = 8'h80;
            4'd7:    b = 8'h80;
            4'd8:    b = 8'h05;
            4'd9:    b = {4'b0010, ts[32:30], 1'b1};
            4'd10:   b = ts[29:22];
            4'd11:   b = {ts[21:15], 1'b1};
            4'd12:   b = ts[14:7];
            4'd13:   b = {ts[6:0], 1'b1};
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aud_pes_rd_ctrl.sv
// Burst read controller. Waits for the half-full flag, then pops up to
// BURST_LEN bytes (pausing on empty or while hold is high) and returns to idle.
// Assumes a first-word-fall-through FIFO: a pop is rd_en high on a clock edge.
module aud_pes_rd_ctrl
    import aud_pes_pkg::*;
#(
    parameter int BURST_LEN = 576
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic fifo_half,
    input  logic hold,
    output logic rd_en
);
    localparam int CW = $clog2(BURST_LEN);

    rd_state_e       state;
    logic [CW-1:0]   cnt;

    // Pop only inside a burst, with data present and no header in progress.
    always_comb rd_en = (state == RD_BURST) && !fifo_empty && !hold;

    // Burst state and pop counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                RD_IDLE: if (fifo_half) begin
                    state <= RD_BURST;
                    cnt   <= '0;
                end
                default: if (rd_en) begin
                    if (cnt == CW'(BURST_LEN - 1)) begin
                        state <= RD_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/aud_pes_frame_track.sv
// Frame tracker. Matches the four-byte sync word on popped bytes, locks once,
// then counts FRAME_LEN bytes per frame and flags the pop of each last byte.
// Assumes FRAME_LEN > 4 and that frames after lock are exactly FRAME_LEN long.
module aud_pes_frame_track
    import aud_pes_pkg::*;
#(
    parameter int FRAME_LEN = 576
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pop,
    input  logic [7:0] din,
    output logic       frame_end
);
    localparam int CW = $clog2(FRAME_LEN);

    logic [23:0]   hist;
    logic          locked;
    logic [CW-1:0] pos;
    logic          match;

    // Sync word seen on this pop, given the three earlier popped bytes.
    always_comb match = pop && ({hist, din} == SYNC_WORD);

    // Last byte of a locked frame is being popped.
    always_comb frame_end = pop && locked && (pos == CW'(FRAME_LEN - 1));

    // Byte history, lock flag and position of the next byte within its frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist   <= '0;
            locked <= 1'b0;
            pos    <= '0;
        end else if (pop) begin
            hist <= {hist[15:0], din};
            if (!locked && match) begin
                locked <= 1'b1;
                pos    <= CW'(4);
            end else if (locked) begin
                pos <= frame_end ? '0 : pos + 1'b1;
            end
        end
    end

endmodule

// File: rtl/aud_pes_hdr_emit.sv
// Header emitter. On start it captures the timestamp and steps through the
// 14 header bytes, one per cycle. Assumes start never arrives while active.
module aud_pes_hdr_emit
    import aud_pes_pkg::*;
#(
    parameter int PKT_LEN = 584
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [32:0] ts_in,
    output logic        active,
    output logic        first,
    output logic [7:0]  byte_out
);
    localparam logic [3:0] LAST = 4'(HDR_LEN - 1);

    logic [3:0]  idx;
    logic [32:0] ts_q;

    // Current header byte and first-byte marker.
    always_comb begin
        byte_out = pes_hdr_byte(idx, 16'(PKT_LEN), ts_q);
        first    = active && (idx == 4'd0);
    end

    // Timestamp capture and header byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            ts_q   <= '0;
        end else if (start) begin
            ts_q   <= ts_in;
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == LAST) active <= 1'b0;
            idx <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/aud_pes_inserter.sv
// Top: pops audio bytes in frame-sized bursts, locks onto frame boundaries and
// puts a 14-byte packet header with the captured timestamp before each frame.
// Assumes a first-word-fall-through FIFO and FRAME_LEN > 4.
module aud_pes_inserter #(
    parameter int FRAME_LEN = 576,
    parameter int PKT_LEN   = FRAME_LEN + 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  fifo_rdata,
    input  logic        fifo_empty,
    input  logic        fifo_half,
    output logic        fifo_rd_en,
    input  logic [32:0] pts,
    output logic [7:0]  out_data,
    output logic        out_valid,
    output logic        pkt_start,
    output logic        frame_sync
);
    logic       hdr_active;
    logic       hdr_first;
    logic [7:0] hdr_byte;
    logic       frame_end;

    aud_pes_rd_ctrl #(.BURST_LEN(FRAME_LEN)) rd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_half  (fifo_half),
        .hold       (hdr_active),
        .rd_en      (fifo_rd_en)
    );

    aud_pes_frame_track #(.FRAME_LEN(FRAME_LEN)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (fifo_rd_en),
        .din       (fifo_rdata),
        .frame_end (frame_end)
    );

    aud_pes_hdr_emit #(.PKT_LEN(PKT_LEN)) hdr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frame_end),
        .ts_in    (pts),
        .active   (hdr_active),
        .first    (hdr_first),
        .byte_out (hdr_byte)
    );

    // Output register: header bytes take priority, otherwise the popped byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data   <= '0;
            out_valid  <= 1'b0;
            pkt_start  <= 1'b0;
            frame_sync <= 1'b0;
        end else begin
            frame_sync <= frame_end;
            if (hdr_active) begin
                out_data  <= hdr_byte;
                out_valid <= 1'b1;
                pkt_start <= hdr_first;
            end else begin
                out_valid <= fifo_rd_en;
                pkt_start <= 1'b0;
                if (fifo_rd_en) out_data <= fifo_rdata;
            end
        end
    end

endmodule

// File: rtl/aud_pes_inserter_chk.sv
// Protocol checker for the inserter, attached by bind below.
module aud_pes_inserter_chk #(
    parameter int HDR_LEN = 14
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  fifo_rdata,
    input logic        fifo_empty,
    input logic        fifo_rd_en,
    input logic [7:0]  out_data,
    input logic        out_valid,
    input logic        pkt_start,
    input logic        frame_sync
);
    logic [3:0] win;

    // Counts the header window that follows a frame_sync cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          win <= '0;
        else if (frame_sync) win <= 4'(HDR_LEN - 1);
        else if (win != 0)   win <= win - 1'b1;
    end

    // R9: never pop an empty FIFO
    assert_no_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> !fifo_empty);

    // R4: a popped byte appears unchanged in the next cycle
    assert_pass_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_rd_en) |-> (out_valid && !pkt_start && out_data == $past(fifo_rdata)));

    // R5: frame_sync is a single-cycle pulse
    assert_sync_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !frame_sync);

    // R6: header starts the cycle after frame_sync with a 00 byte
    assert_hdr_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (pkt_start && out_valid && out_data == 8'h00));

    // R8: reads held off across the header window
    assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync || win != 0) |-> !fifo_rd_en);

endmodule

bind aud_pes_inserter aud_pes_inserter_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_rdata (fifo_rdata),
    .fifo_empty (fifo_empty),
    .fifo_rd_en (fifo_rd_en),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .pkt_start  (pkt_start),
    .frame_sync (frame_sync)
);

// File: tb/aud_pes_inserter_tb_top.sv
`timescale 1ns/1ps
module aud_pes_inserter_tb_top;
    localparam int FL   = 24;
    localparam int PL   = 32;
    localparam int HB   = 14;
    localparam logic [32:0] STEP = 33'h0_0123_4567;

    typedef struct packed {
        int          garbage;
        int          frames;
        int          chunk;
        int          gap;
        int          fake;
        logic [32:0] pts0;
    } scen_t;

    localparam scen_t SCEN [0:4] = '{
        '{3,  3, 0,  0, 0, 33'h0_1234_5678},
        '{0,  2, 5,  9, 0, 33'h1_FFFF_FFF0},
        '{7,  3, 0,  0, 1, 33'h1_5555_AAAA},
        '{40, 0, 0,  0, 0, 33'h0_0000_0000},
        '{2,  4, 11, 3, 1, 33'h0_0000_0001}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_half = 1'b0;
    logic        fifo_rd_en, fifo_empty;
    logic [7:0]  fifo_rdata;
    logic [32:0] pts;
    logic [7:0]  out_data;
    logic        out_valid, pkt_start, frame_sync;

    always #2.5 clk = ~clk;

    // Bench FIFO model (first-word-fall-through)
    logic [7:0] mem [0:4095];
    int wr_ptr = 0;
    int rd_ptr = 0;
    logic fifo_clr = 1'b1;
    assign fifo_empty = (wr_ptr == rd_ptr);
    assign fifo_rdata = mem[rd_ptr & 4095];

    always @(posedge clk) begin
        if (fifo_clr) rd_ptr <= 0;
        else if (fifo_rd_en && !fifo_empty) rd_ptr <= rd_ptr + 1;
    end

    aud_pes_inserter #(.FRAME_LEN(FL), .PKT_LEN(PL)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_rdata (fifo_rdata),
        .fifo_empty (fifo_empty),
        .fifo_half  (fifo_half),
        .fifo_rd_en (fifo_rd_en),
        .pts        (pts),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .pkt_start  (pkt_start),
        .frame_sync (frame_sync)
    );

    // Monitor: capture output, step pts after each frame_sync, check read hold (R8)
    logic [7:0]  cap_d [0:1023];
    logic        cap_p [0:1023];
    int          ncap = 0, nsync = 0, win = 0;
    int          mon_checks = 0, mon_errs = 0;
    logic        cap_clr = 1'b1;
    logic [32:0] pts_load = '0;

    always @(negedge clk) begin
        if (cap_clr) begin
            ncap = 0; nsync = 0; win = 0; pts = pts_load;
        end else if (rst_n) begin
            if (out_valid && ncap < 1024) begin
                cap_d[ncap] = out_data; cap_p[ncap] = pkt_start; ncap++;
            end
            if (frame_sync) begin
                nsync++; win = HB; pts = pts + STEP;
            end
            if (win > 0) begin
                mon_checks++;
                if (fifo_rd_en) begin
                    mon_errs++;
                    $display("FAIL R8 read during header: actual rd_en=1 expected 0");
                end
                win--;
            end
        end
    end

    int checks = 0, errors = 0, cycles = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic logic [7:0] exp_hdr(input int k, input logic [32:0] t);
        case (k)
            0, 1:    return 8'h00;
            2:       return 8'h01;
            3:       return 8'hC0;
            4:       return 8'(PL >> 8);
            5:       return 8'(PL & 255);
            6, 7:    return 8'h80;
            8:       return 8'h05;
            9:       return {4'b0010, t[32:30], 1'b1};
            10:      return t[29:22];
            11:      return {t[21:15], 1'b1};
            12:      return t[14:7];
            default: return {t[6:0], 1'b1};
        endcase
    endfunction

    logic [7:0] inb   [0:1023];
    logic [7:0] exp_d [0:1023];
    logic       exp_p [0:1023];
    int ninb, nexp;

    task automatic do_reset(input logic [32:0] p0);
        @(negedge clk);
        rst_n = 1'b0; cap_clr = 1'b1; fifo_clr = 1'b1; fifo_half = 1'b0;
        wr_ptr = 0; pts_load = p0;
        repeat (3) @(negedge clk);
        check(!fifo_rd_en && !out_valid && !pkt_start && !frame_sync, "R1 outputs in reset",
              {fifo_rd_en, out_valid, pkt_start, frame_sync}, 0);
        cap_clr = 1'b0; fifo_clr = 1'b0; rst_n = 1'b1;
    endtask

    task automatic push(input logic [7:0] b);
        mem[wr_ptr & 4095] = b;
        wr_ptr = wr_ptr + 1;
    endtask

    task automatic run_scen(input scen_t s);
        logic [32:0] t;
        do_reset(s.pts0);
        ninb = 0; nexp = 0; t = s.pts0;
        for (int i = 0; i < s.garbage; i++) begin
            inb[ninb] = 8'((i * 7 + 3) & 127);
            exp_d[nexp] = inb[ninb]; exp_p[nexp] = 1'b0; ninb++; nexp++;
        end
        for (int f = 0; f < s.frames; f++) begin
            for (int i = 0; i < FL; i++) begin
                logic [7:0] b;
                b = 8'((f * 37 + i * 5 + 9) & 127);
                if (i == 0 || (s.fake != 0 && f == 1 && i == 8)) b = 8'hFF;
                if (i == 1 || (s.fake != 0 && f == 1 && i == 9)) b = 8'hFD;
                if (i == 2 || (s.fake != 0 && f == 1 && i == 10)) b = 8'hC4;
                if (i == 3 || (s.fake != 0 && f == 1 && i == 11)) b = 8'h00;
                inb[ninb] = b; exp_d[nexp] = b; exp_p[nexp] = 1'b0; ninb++; nexp++;
            end
            for (int k = 0; k < HB; k++) begin
                exp_d[nexp] = exp_hdr(k, t); exp_p[nexp] = (k == 0); nexp++;
            end
            t = t + STEP;
        end
        fifo_half = 1'b1;
        for (int i = 0; i < ninb; i++) begin
            push(inb[i]);
            if (s.chunk > 0 && ((i + 1) % s.chunk) == 0) repeat (s.gap) @(negedge clk);
        end
        for (int w = 0; w < 4000 && ncap < nexp; w++) @(negedge clk);
        repeat (30) @(negedge clk);
        // R4 R5 R6 R7 R9 R10: byte stream, header contents and placement
        check(ncap == nexp, "R4/R10 output byte count", ncap, nexp);
        for (int i = 0; i < nexp && i < ncap; i++) begin
            check(cap_d[i] == exp_d[i], $sformatf("R6 R7 R9 byte %0d", i), cap_d[i], exp_d[i]);
            check(cap_p[i] == exp_p[i], $sformatf("R6 pkt_start at %0d", i), cap_p[i], exp_p[i]);
        end
        check(nsync == s.frames, "R5 frame_sync count", nsync, s.frames);
        fifo_half = 1'b0;
    endtask

    initial begin
        // Table-driven scenarios
        for (int s = 0; s < 5; s++) run_scen(SCEN[s]);

        // Directed: half-full gating and burst length (R2, R3), pass-through timing (R4)
        do_reset(33'h0);
        for (int i = 0; i < 40; i++) push(8'((i * 3 + 1) & 127));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check(!fifo_rd_en, "R2 no read before half-full", fifo_rd_en, 0);
        end
        check(ncap == 0, "R2 no output before half-full", ncap, 0);
        fifo_half = 1'b1;
        @(negedge clk);
        fifo_half = 1'b0;
        check(fifo_rd_en, "R2 read starts after half-full", fifo_rd_en, 1);
        @(negedge clk);
        check(out_valid && out_data == 8'h01, "R4 byte one cycle after pop", out_data, 1);
        repeat (60) @(negedge clk);
        check(rd_ptr == FL, "R3 burst stops after one frame", rd_ptr, FL);
        check(!fifo_rd_en, "R3 idle until next half-full", fifo_rd_en, 0);
        fifo_half = 1'b1;
        @(negedge clk);
        fifo_half = 1'b0;
        repeat (60) @(negedge clk);
        check(rd_ptr == 40, "R3 second burst drains rest", rd_ptr, 40);
        check(ncap == 40, "R10 unlocked bytes all passed", ncap, 40);
        finish_run();
    end

endmodule